// File: doc/BRIEF.md
# Vector element register index generator

This block turns the register field of a decoded instruction into the sequence of physical register indices that a vector operation touches. It emits one index per element, one element per cycle, until it reaches the vector length. Physical indices are not formed by adding consecutive offsets to the base. The architectural field is widened with extra low-order bits instead: two for the integer file and three for the condition-register (CR) file. As a result, the elements of a vector sit between the legacy registers. A legacy or scalar operand always gets all-zero low bits, so it lands on the register that older code expects.

A run is launched with a start handshake that carries the file select, the field, the scalar flag, the vector length and a stride exponent. The stride exponent makes the element step 2^n instead of 1. That lets software skip interleaved registers that a smaller register file does not have. For vector instructions that write condition results, the CR base can be forced to field 6. Indices leave on a valid/ready stream with a last flag. An element whose index would fall outside its file is not issued: the run ends there and an error flag is raised.

Top module: `velem_index_gen`

## Requirements
- R1: For the integer file (`startFile`=0), element k has index (field << 2) + (k << stride), and indices must be below 128.
- R2: For the CR file (`startFile`=1), only the low 3 bits of the field are used, and element k has index (field << 3) + (k << stride), below 64. With stride 0, element 8 of a run based at field b lands on (b+1) << 3, and a run of length 8 never reaches it.
- R3: A scalar start (`startScalar`=1) emits exactly one element, whose index is the field shifted left with zero low bits and whose last flag is set. The vector length, the stride and the CR default are ignored.
- R4: A vector start with length 0 emits no element, and `startReady` stays high.
- R5: A vector CR start with `startRcDefault`=1 uses base field 6 and ignores `startField`. For integer or scalar starts the flag has no effect.
- R6: The stride exponent n makes consecutive elements differ by 2^n, and element 0 keeps zero low bits.
- R7: An element whose index would reach the file size is not issued. The run ends, `ovfErr` goes high and stays high until the next accepted start clears it. No element of a truncated run carries last.
- R8: While `outValid` is high and `outReady` is low, `outValid`, `outIndex` and `outLast` hold their values.
- R9: The first element is valid in the cycle after the start is accepted. With `outReady` high, elements follow back to back, and `outLast` is set only on element VL-1.
- R10: `startReady` is high only when idle, and a start offered while busy has no effect. Reset leaves the block idle with `outValid` and `ovfErr` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| startValid | input | 1 | Start request |
| startReady | output | 1 | Idle; a start is taken on this edge |
| startFile | input | 1 | 0 integer file, 1 CR file |
| startField | input | 5 | Architectural register field |
| startScalar | input | 1 | Operand is scalar/legacy |
| startRcDefault | input | 1 | Force CR base to field 6 for vector CR writes |
| startVecLen | input | 7 | Vector length |
| startStrideLog2 | input | 2 | Element step exponent |
| outValid | output | 1 | Element index valid |
| outReady | input | 1 | Consumer takes the element |
| outIndex | output | 7 | Physical register index |
| outLast | output | 1 | Final element of the run |
| ovfErr | output | 1 | Run truncated by an out-of-file index |

## Verification
The first index appears one edge after the start is accepted, because the configuration and element counter are registered and the index is formed combinationally from them. Each later index follows one edge after the previous handshake. The overflow flag and the return to idle appear one edge after the last good handshake, since the out-of-range element is first detected in that cycle. The bench drives inputs and samples outputs on falling edges. After each accepted start it checks, cycle by cycle, whether valid is expected, and it compares each index and last flag against the formula as the element is taken. Stall, busy-start, sticky-error and mid-run reset cases are checked on the exact falling edge that follows the relevant rising edge.

// File: rtl/velem_pkg.sv
package velem_pkg;

  localparam int FILE_INT = 0;
  localparam int FILE_CR  = 1;
  localparam int NUM_FILES = 2;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;     // capture a new run configuration, clear element count
    logic advance;  // step to the next element
  } ctrlStrobe_t;

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/velem_dpath.sv
module velem_dpath
  import velem_pkg::*;
#(
  parameter int INT_ARCH_W  = 5,
  parameter int INT_EXTRA_W = 2,
  parameter int CR_ARCH_W   = 3,
  parameter int CR_EXTRA_W  = 3,
  parameter int VL_W        = 7,
  parameter int STRIDE_W    = 2,
  parameter int CR_RC_BASE  = 6,
  localparam int ARCH_W = maxInt(INT_ARCH_W, CR_ARCH_W),
  localparam int IDX_W  = maxInt(INT_ARCH_W + INT_EXTRA_W, CR_ARCH_W + CR_EXTRA_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ctrlStrobe_t         strobe,
  input  logic                inFile,
  input  logic [ARCH_W-1:0]   inField,
  input  logic                inScalar,
  input  logic                inRcDefault,
  input  logic [VL_W-1:0]     inVecLen,
  input  logic [STRIDE_W-1:0] inStride,
  output logic                emptyReq,
  output logic [IDX_W-1:0]    idx,
  output logic                inRange,
  output logic                lastElem
);

  localparam int SUM_W = IDX_W + VL_W + (2 ** STRIDE_W);

  logic                fileQ;
  logic [ARCH_W-1:0]   baseQ;
  logic                scalarQ;
  logic [VL_W-1:0]     vlm1Q;
  logic [STRIDE_W-1:0] strideQ;
  logic [VL_W-1:0]     elemQ;

  logic [SUM_W-1:0]     sumArr [NUM_FILES];
  logic [NUM_FILES-1:0] rangeVec;

  // Configuration capture and element counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fileQ   <= 1'b0;
      baseQ   <= '0;
      scalarQ <= 1'b0;
      vlm1Q   <= '0;
      strideQ <= '0;
      elemQ   <= '0;
    end else if (strobe.load) begin
      fileQ   <= inFile;
      scalarQ <= inScalar;
      vlm1Q   <= inVecLen - VL_W'(1);
      strideQ <= inScalar ? '0 : inStride;
      elemQ   <= '0;
      if (inFile && inRcDefault && !inScalar) begin
        baseQ <= ARCH_W'(CR_RC_BASE);
      end else begin
        baseQ <= inField;
      end
    end else if (strobe.advance) begin
      elemQ <= elemQ + VL_W'(1);
    end
  end

  // One index adder and range compare per register file
  for (genvar f = 0; f < NUM_FILES; f++) begin : g_file
    localparam int AW = (f == FILE_CR) ? CR_ARCH_W : INT_ARCH_W;
    localparam int EW = (f == FILE_CR) ? CR_EXTRA_W : INT_EXTRA_W;
    localparam int PW = AW + EW;
    assign sumArr[f]   = (SUM_W'(baseQ[AW-1:0]) << EW) + (SUM_W'(elemQ) << strideQ);
    assign rangeVec[f] = sumArr[f] < (SUM_W'(1) << PW);
  end

  assign idx      = IDX_W'(sumArr[fileQ]);
  assign inRange  = rangeVec[fileQ];
  assign lastElem = scalarQ || (elemQ == vlm1Q);
  assign emptyReq = !inScalar && (inVecLen == '0);

  AST_SCALAR_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n) (scalarQ && !strobe.load) |-> (elemQ == '0)); // R3

endmodule

// File: rtl/velem_ctrl.sv
module velem_ctrl
  import velem_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        startValid,
  output logic        startReady,
  input  logic        emptyReq,
  input  logic        inRange,
  input  logic        lastElem,
  input  logic        outReady,
  output logic        outValid,
  output logic        outLast,
  output logic        ovfErr,
  output ctrlStrobe_t strobe
);

  logic busyQ;
  logic errQ;
  logic accept;
  logic fire;

  assign startReady = !busyQ;
  assign accept     = startValid && !busyQ;
  assign outValid   = busyQ && inRange;
  assign outLast    = outValid && lastElem;
  assign fire       = outValid && outReady;
  assign ovfErr     = errQ;

  always_comb begin
    strobe         = '0;
    strobe.load    = accept;
    strobe.advance = fire && !lastElem;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busyQ <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      if (accept) begin
        busyQ <= !emptyReq;
        errQ  <= 1'b0;
      end else if (fire && lastElem) begin
        busyQ <= 1'b0;
      end else if (busyQ && !inRange) begin
        busyQ <= 1'b0;
        errQ  <= 1'b1;
      end
    end
  end

  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n) startReady |-> !outValid); // R10
  AST_EMPTY_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n) (startValid && startReady && emptyReq) |=> (startReady && !outValid)); // R4
  AST_LAST_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n) (outValid && outReady && outLast) |=> !outValid); // R9
  AST_ERR_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n) $rose(ovfErr) |-> (startReady && !outValid)); // R7

endmodule

// File: rtl/velem_index_gen.sv
module velem_index_gen
  import velem_pkg::*;
#(
  parameter int INT_ARCH_W  = 5,
  parameter int INT_EXTRA_W = 2,
  parameter int CR_ARCH_W   = 3,
  parameter int CR_EXTRA_W  = 3,
  parameter int VL_W        = 7,
  parameter int STRIDE_W    = 2,
  parameter int CR_RC_BASE  = 6,
  localparam int ARCH_W = maxInt(INT_ARCH_W, CR_ARCH_W),
  localparam int IDX_W  = maxInt(INT_ARCH_W + INT_EXTRA_W, CR_ARCH_W + CR_EXTRA_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                startValid,
  output logic                startReady,
  input  logic                startFile,
  input  logic [ARCH_W-1:0]   startField,
  input  logic                startScalar,
  input  logic                startRcDefault,
  input  logic [VL_W-1:0]     startVecLen,
  input  logic [STRIDE_W-1:0] startStrideLog2,
  output logic                outValid,
  input  logic                outReady,
  output logic [IDX_W-1:0]    outIndex,
  output logic                outLast,
  output logic                ovfErr
);

  localparam int MIN_EXTRA = (INT_EXTRA_W < CR_EXTRA_W) ? INT_EXTRA_W : CR_EXTRA_W;

  ctrlStrobe_t strobe;
  logic        emptyReq;
  logic        inRange;
  logic        lastElem;

  velem_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .startValid (startValid),
    .startReady (startReady),
    .emptyReq   (emptyReq),
    .inRange    (inRange),
    .lastElem   (lastElem),
    .outReady   (outReady),
    .outValid   (outValid),
    .outLast    (outLast),
    .ovfErr     (ovfErr),
    .strobe     (strobe)
  );

  velem_dpath #(
    .INT_ARCH_W  (INT_ARCH_W),
    .INT_EXTRA_W (INT_EXTRA_W),
    .CR_ARCH_W   (CR_ARCH_W),
    .CR_EXTRA_W  (CR_EXTRA_W),
    .VL_W        (VL_W),
    .STRIDE_W    (STRIDE_W),
    .CR_RC_BASE  (CR_RC_BASE)
  ) u_dpath (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .inFile      (startFile),
    .inField     (startField),
    .inScalar    (startScalar),
    .inRcDefault (startRcDefault),
    .inVecLen    (startVecLen),
    .inStride    (startStrideLog2),
    .emptyReq    (emptyReq),
    .idx         (outIndex),
    .inRange     (inRange),
    .lastElem    (lastElem)
  );

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (outValid && !outReady) |=> (outValid && $stable(outIndex) && $stable(outLast))); // R8
  AST_FIRST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) ($past(startValid && startReady) && outValid) |-> (outIndex[MIN_EXTRA-1:0] == '0)); // R6

endmodule

// File: tb/velem_index_gen_tb.sv
`timescale 1ns/1ps
module velem_index_gen_tb;

  typedef struct packed {
    logic       file;
    logic       rc;
    logic       scalar;
    logic [4:0] field;
    logic [6:0] vl;
    logic [1:0] stride;
    logic [7:0] expCount;
    logic       expOvf;
  } vec_t;

  // file rc scalar field vl stride expCount expOvf
  localparam vec_t VECS [12] = '{
    '{1'b0, 1'b0, 1'b0, 5'd5,  7'd4,  2'd0, 8'd4, 1'b0},
    '{1'b1, 1'b0, 1'b0, 5'd1,  7'd9,  2'd0, 8'd9, 1'b0},
    '{1'b1, 1'b0, 1'b0, 5'd1,  7'd8,  2'd0, 8'd8, 1'b0},
    '{1'b0, 1'b0, 1'b0, 5'd31, 7'd6,  2'd0, 8'd4, 1'b1},
    '{1'b0, 1'b0, 1'b1, 5'd3,  7'd10, 2'd2, 8'd1, 1'b0},
    '{1'b1, 1'b1, 1'b0, 5'd2,  7'd3,  2'd0, 8'd3, 1'b0},
    '{1'b0, 1'b0, 1'b0, 5'd0,  7'd0,  2'd0, 8'd0, 1'b0},
    '{1'b0, 1'b0, 1'b0, 5'd2,  7'd5,  2'd2, 8'd5, 1'b0},
    '{1'b1, 1'b0, 1'b0, 5'd7,  7'd3,  2'd3, 8'd1, 1'b1},
    '{1'b1, 1'b0, 1'b0, 5'd0,  7'd1,  2'd0, 8'd1, 1'b0},
    '{1'b1, 1'b1, 1'b1, 5'd4,  7'd0,  2'd1, 8'd1, 1'b0},
    '{1'b0, 1'b0, 1'b0, 5'd10, 7'd3,  2'd1, 8'd3, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       startValid = 1'b0;
  logic       startReady;
  logic       startFile = 1'b0;
  logic [4:0] startField = '0;
  logic       startScalar = 1'b0;
  logic       startRcDefault = 1'b0;
  logic [6:0] startVecLen = '0;
  logic [1:0] startStrideLog2 = '0;
  logic       outValid;
  logic       outReady = 1'b1;
  logic [6:0] outIndex;
  logic       outLast;
  logic       ovfErr;

  int vectors = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  velem_index_gen u_dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .startValid      (startValid),
    .startReady      (startReady),
    .startFile       (startFile),
    .startField      (startField),
    .startScalar     (startScalar),
    .startRcDefault  (startRcDefault),
    .startVecLen     (startVecLen),
    .startStrideLog2 (startStrideLog2),
    .outValid        (outValid),
    .outReady        (outReady),
    .outIndex        (outIndex),
    .outLast         (outLast),
    .ovfErr          (ovfErr)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int expIdx(input vec_t v, input int k);
    int base;
    int step;
    base = (v.file && v.rc && !v.scalar) ? 6 : int'(v.field);
    step = v.scalar ? 0 : (k << v.stride);
    if (v.file) return ((base & 7) << 3) + step;
    return ((base & 31) << 2) + step;
  endfunction

  function automatic string tagFor(input vec_t v);
    if (v.scalar) return "R3";
    if (v.vl == 0) return "R4";
    if (v.expOvf) return "R7";
    if (v.file && v.rc) return "R5";
    if (v.stride != 0) return "R6";
    if (v.file) return "R2";
    return "R1";
  endfunction

  task automatic offerStart(input logic f, input logic rc, input logic sc,
                            input logic [4:0] fld, input logic [6:0] vl, input logic [1:0] st);
    startValid      = 1'b1;
    startFile       = f;
    startRcDefault  = rc;
    startScalar     = sc;
    startField      = fld;
    startVecLen     = vl;
    startStrideLog2 = st;
  endtask

  // Entered on a falling edge while idle; returns on a falling edge while idle
  task automatic runVec(input vec_t v);
    int k;
    string tag;
    tag = tagFor(v);
    outReady = 1'b1;
    offerStart(v.file, v.rc, v.scalar, v.field, v.vl, v.stride);
    @(negedge clk);
    startValid = 1'b0;
    k = 0;
    for (int cyc = 0; cyc < 300 && !startReady; cyc++) begin
      check(tag, "valid (R9 timing)", int'(outValid), int'(k < int'(v.expCount)));
      if (outValid) begin
        check(tag, "index", int'(outIndex), expIdx(v, k));
        check(tag, "last (R9)", int'(outLast), int'(v.scalar || (k == int'(v.vl) - 1)));
        k++;
      end
      @(negedge clk);
    end
    check(tag, "element count", k, int'(v.expCount));
    check(tag, "overflow flag", int'(ovfErr), int'(v.expOvf));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL R9 watchdog expired actual=hung expected=done");
    miscompares++;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "reset valid", int'(outValid), 0);
    check("R10", "reset ready", int'(startReady), 1);
    check("R10", "reset ovf", int'(ovfErr), 0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VECS[i]) runVec(VECS[i]);

    // R7: error flag stays up until the next accepted start
    runVec(VECS[3]);
    repeat (3) @(negedge clk);
    check("R7", "ovf sticky while idle", int'(ovfErr), 1);
    runVec(VECS[0]);
    check("R7", "ovf cleared by start", int'(ovfErr), 0);

    // R8 and R10: stall with a competing start offered while busy
    outReady = 1'b0;
    offerStart(1'b0, 1'b0, 1'b0, 5'd4, 7'd3, 2'd0);
    @(negedge clk);
    offerStart(1'b1, 1'b0, 1'b0, 5'd2, 7'd5, 2'd1);
    check("R9", "first valid", int'(outValid), 1);
    check("R8", "stall index", int'(outIndex), 16);
    check("R8", "stall last", int'(outLast), 0);
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      check("R8", "held valid", int'(outValid), 1);
      check("R8", "held index", int'(outIndex), 16);
      check("R10", "busy ready low", int'(startReady), 0);
    end
    startValid = 1'b0;
    outReady = 1'b1;
    @(negedge clk);
    check("R8", "after stall index", int'(outIndex), 17);
    @(negedge clk);
    check("R8", "final index", int'(outIndex), 18);
    check("R9", "final last", int'(outLast), 1);
    @(negedge clk);
    check("R10", "idle after run", int'(startReady), 1);
    @(negedge clk);
    check("R10", "busy start ignored", int'(outValid), 0);

    // R10: reset in the middle of a run
    offerStart(1'b0, 1'b0, 1'b0, 5'd1, 7'd10, 2'd0);
    @(negedge clk);
    startValid = 1'b0;
    repeat (2) @(negedge clk);
    check("R9", "mid-run index", int'(outIndex), 6);
    rst_n = 1'b0;
    #1;
    check("R10", "reset valid mid-run", int'(outValid), 0);
    check("R10", "reset ready mid-run", int'(startReady), 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    runVec(VECS[11]);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule